// File: doc/BRIEF.md
# Language card bank switch

This block manages the top 12 KB of four 64 KB banks: the two fast banks $00 and $01 and the two slow banks $E0 and $E1. It watches every CPU access. When the address falls in the sixteen soft-switch locations $C080–$C08F, it updates three things. The first is whether reads of $D000–$FFFF return ROM or RAM. The second is whether writes there reach RAM. The third is which of two 4 KB RAM banks sits behind $D000–$DFFF. The upper 8 KB at $E000–$FFFF always shows the same RAM.

For each of eight windows the block reports a read source, a write enable and a physical RAM offset. There is one $D000 window and one $E000 window in each of the four banks. The memory datapath uses these to steer its accesses. Two side inputs change the fast banks only. An inhibit input makes both windows of banks $00 and $01 plain read/write main RAM. A zero-page auxiliary select moves the bank $00 RAM into auxiliary memory. The slow banks always follow the switch state, and both of them map to the same slow RAM.

Top module: `lc_bank_switch`

## Requirements
- R1: After reset, every window is set to read ROM (`win_rd_ram_o`=0) with writes enabled (`win_wr_en_o`=1). Every window also has bank 2 selected. Bank 2 puts the $D000 window at bank base + $D000.
- R2: Only an access with `acc_valid_i`=1 and `(acc_addr_i & 16'hFFF0) == 16'hC080` changes the switch state. Any other address, or an address presented while `acc_valid_i`=0, leaves every output unchanged.
- R3: A switch access with address bits [1:0] = 00 or 11 selects RAM for reads (`win_rd_ram_o`=1). Bits [1:0] = 01 or 10 select ROM. The new value is visible in the cycle after the access.
- R4: On a switch access, address bit 3 = 1 selects bank 1 and bit 3 = 0 selects bank 2. With bank 1 the $D000 window (even window index) is at bank base + $C000, and with bank 2 it is at bank base + $D000. The $E000 window (odd index) is always at bank base + $E000.
- R5: Two read accesses to odd switch addresses (bit 0 = 1) set write enable. The two reads need not be adjacent bus cycles: accesses outside $C080–$C08F between them do not break the pair. A single odd read does not set write enable.
- R6: Any even switch access, read or write, clears write enable and the pending first read. An odd switch write also clears the pending first read but does not change write enable.
- R7: When `zp_aux_i`=1 and `lc_inhibit_i`=0, both bank $00 window offsets gain $1_0000 and so equal the bank $01 offsets. Banks $01, $E0 and $E1 are unaffected.
- R8: When `lc_inhibit_i`=1, the four windows of banks $00 and $01 read RAM with writes enabled. Their offsets become bank base + $D000 and bank base + $E000, whatever the switch state or `zp_aux_i` is.
- R9: The windows of banks $E0 and $E1 follow the switch state and ignore `zp_aux_i` and `lc_inhibit_i`. Their offsets are computed from `SLOW_BASE`, the same for both banks. Window indices are bank $00 = 0/1, $01 = 2/3, $E0 = 4/5 and $E1 = 6/7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | A CPU access is on the bus this cycle |
| acc_read_i | input | 1 | 1 = read access, 0 = write access |
| acc_addr_i | input | 16 | Access address within the bank |
| zp_aux_i | input | 1 | Zero-page auxiliary select |
| lc_inhibit_i | input | 1 | Turns the windows of banks $00/$01 into plain RAM |
| win_rd_ram_o | output | 8 | Per window: 1 = reads from RAM, 0 = reads from ROM |
| win_wr_en_o | output | 8 | Per window: writes reach RAM |
| win_ofs_o | output | 8 x RAM_AW | Per window: physical RAM address of the window start |

## Verification
The hardest state to reach is the write-enable pairing: the pending first read is hidden and only shows up in the cycle after a second odd read. The stimulus therefore builds exact sequences for this. One sequence puts a single odd read after a clearing even access. Another interleaves a non-switch access between two odd reads. A third places an odd write between two odd reads, so that both the pending state and its clearing show up on `win_wr_en_o`. The inhibit and auxiliary inputs are checked against a switch state of ROM read with writes disabled, so that a forced-RAM result can be told apart from a result the switches alone would give.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int NUM_BANKS = 4;
  localparam int NUM_WIN   = 2 * NUM_BANKS;

  typedef enum int {BK_00 = 0, BK_01 = 1, BK_E0 = 2, BK_E1 = 3} bank_idx_e;

  typedef struct packed {
    logic rd_ram;
    logic wr_en;
    logic bank1;
  } lc_state_t;
endpackage

// File: rtl/lc_switch_fsm.sv
module lc_switch_fsm
  import lc_pkg::*;
#(
  parameter logic [15:0] SW_BASE = 16'hC080,
  parameter logic [15:0] SW_MASK = 16'hFFF0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        acc_valid_i,
  input  logic        acc_read_i,
  input  logic [15:0] acc_addr_i,
  output lc_state_t   state_o
);
  logic hit;
  logic pre_wr_q;
  lc_state_t st_q;

  assign hit = acc_valid_i && ((acc_addr_i & SW_MASK) == SW_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q.rd_ram <= 1'b0;
      st_q.wr_en  <= 1'b1;
      st_q.bank1  <= 1'b0;
      pre_wr_q    <= 1'b0;
    end else if (hit) begin
      st_q.rd_ram <= (acc_addr_i[1:0] == 2'b00) || (acc_addr_i[1:0] == 2'b11);
      st_q.bank1  <= acc_addr_i[3];
      if (acc_addr_i[0]) begin
        if (acc_read_i) begin
          if (pre_wr_q) st_q.wr_en <= 1'b1;
          pre_wr_q <= 1'b1;
        end else begin
          pre_wr_q <= 1'b0;
        end
      end else begin
        st_q.wr_en <= 1'b0;
        pre_wr_q   <= 1'b0;
      end
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/lc_window_map.sv
module lc_window_map
  import lc_pkg::*;
#(
  parameter int                RAM_AW      = 24,
  parameter logic [RAM_AW-1:0] BANK_BASE   = '0,
  parameter logic [RAM_AW-1:0] AUX_OFS     = RAM_AW'(32'h1_0000),
  parameter bit                HAS_INHIBIT = 1'b0,
  parameter bit                HAS_AUX     = 1'b0
) (
  input  lc_state_t              state_i,
  input  logic                   zp_aux_i,
  input  logic                   inhibit_i,
  output logic [1:0]             rd_ram_o,
  output logic [1:0]             wr_en_o,
  output logic [1:0][RAM_AW-1:0] ofs_o
);
  localparam logic [RAM_AW-1:0] D_OFS  = RAM_AW'(32'hD000);
  localparam logic [RAM_AW-1:0] D1_OFS = RAM_AW'(32'hC000);
  localparam logic [RAM_AW-1:0] E_OFS  = RAM_AW'(32'hE000);

  logic [RAM_AW-1:0] base;

  always_comb begin
    base = BANK_BASE;
    if (HAS_AUX && zp_aux_i) base = BANK_BASE + AUX_OFS;
    if (HAS_INHIBIT && inhibit_i) begin
      rd_ram_o = 2'b11;
      wr_en_o  = 2'b11;
      ofs_o[0] = BANK_BASE + D_OFS;
      ofs_o[1] = BANK_BASE + E_OFS;
    end else begin
      rd_ram_o = {2{state_i.rd_ram}};
      wr_en_o  = {2{state_i.wr_en}};
      // bank 1 sits 4 KB below bank 2
      ofs_o[0] = base + (state_i.bank1 ? D1_OFS : D_OFS);
      ofs_o[1] = base + E_OFS;
    end
  end
endmodule

// File: rtl/lc_bank_switch.sv
module lc_bank_switch
  import lc_pkg::*;
#(
  parameter int                RAM_AW    = 24,
  parameter logic [RAM_AW-1:0] SLOW_BASE = RAM_AW'(32'h7E_0000)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         acc_valid_i,
  input  logic                         acc_read_i,
  input  logic [15:0]                  acc_addr_i,
  input  logic                         zp_aux_i,
  input  logic                         lc_inhibit_i,
  output logic [NUM_WIN-1:0]           win_rd_ram_o,
  output logic [NUM_WIN-1:0]           win_wr_en_o,
  output logic [NUM_WIN-1:0][RAM_AW-1:0] win_ofs_o
);
  localparam logic [RAM_AW-1:0] BANK_SZ = RAM_AW'(32'h1_0000);

  lc_state_t state;

  lc_switch_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_valid_i(acc_valid_i),
    .acc_read_i (acc_read_i),
    .acc_addr_i (acc_addr_i),
    .state_o    (state)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [RAM_AW-1:0] BASE =
      (b == BK_00) ? '0 : (b == BK_01) ? BANK_SZ : SLOW_BASE;
    lc_window_map #(
      .RAM_AW     (RAM_AW),
      .BANK_BASE  (BASE),
      .AUX_OFS    (BANK_SZ),
      .HAS_INHIBIT(b < BK_E0),
      .HAS_AUX    (b == BK_00)
    ) u_map (
      .state_i  (state),
      .zp_aux_i (zp_aux_i),
      .inhibit_i(lc_inhibit_i),
      .rd_ram_o (win_rd_ram_o[2*b+1:2*b]),
      .wr_en_o  (win_wr_en_o[2*b+1:2*b]),
      .ofs_o    (win_ofs_o[2*b+1:2*b])
    );
  end
endmodule

// File: rtl/lc_bank_switch_chk.sv
module lc_bank_switch_chk #(
  parameter int                RAM_AW    = 24,
  parameter logic [RAM_AW-1:0] SLOW_BASE = RAM_AW'(32'h7E_0000)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  acc_valid_i,
  input logic                  acc_read_i,
  input logic [15:0]           acc_addr_i,
  input logic                  zp_aux_i,
  input logic                  lc_inhibit_i,
  input logic [7:0]            win_rd_ram_o,
  input logic [7:0]            win_wr_en_o,
  input logic [7:0][RAM_AW-1:0] win_ofs_o
);
  logic sw_hit;
  assign sw_hit = acc_valid_i && (acc_addr_i[15:4] == 12'hC08);

  p_snoop_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_hit |=> ($stable(win_rd_ram_o[7:4]) && $stable(win_wr_en_o[7:4])
                 && $stable(win_ofs_o[4])));

  p_rd_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_hit |=> (win_rd_ram_o[4] == ($past(acc_addr_i[1:0]) == 2'b00 ||
                                     $past(acc_addr_i[1:0]) == 2'b11)));

  p_bank_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_hit |=> (win_ofs_o[4] == SLOW_BASE +
                ($past(acc_addr_i[3]) ? RAM_AW'(32'hC000) : RAM_AW'(32'hD000))));

  p_ewin_fixed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_ofs_o[5] == SLOW_BASE + RAM_AW'(32'hE000));

  p_wr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_hit && acc_read_i && acc_addr_i[0] && win_wr_en_o[4]) |=> win_wr_en_o[4]);

  p_even_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_hit && !acc_addr_i[0]) |=> !win_wr_en_o[4]);

  p_zp_alias_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zp_aux_i && !lc_inhibit_i) |-> (win_ofs_o[0] == win_ofs_o[2] &&
                                     win_ofs_o[1] == win_ofs_o[3]));

  p_inhibit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lc_inhibit_i |-> (&win_rd_ram_o[3:0] && &win_wr_en_o[3:0]));

  p_slow_same_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd_ram_o[5:4] == win_rd_ram_o[7:6] && win_wr_en_o[5:4] == win_wr_en_o[7:6]
     && win_ofs_o[4] == win_ofs_o[6] && win_ofs_o[5] == win_ofs_o[7]));
endmodule

bind lc_bank_switch lc_bank_switch_chk #(.RAM_AW(RAM_AW), .SLOW_BASE(SLOW_BASE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_read_i  (acc_read_i),
  .acc_addr_i  (acc_addr_i),
  .zp_aux_i    (zp_aux_i),
  .lc_inhibit_i(lc_inhibit_i),
  .win_rd_ram_o(win_rd_ram_o),
  .win_wr_en_o (win_wr_en_o),
  .win_ofs_o   (win_ofs_o)
);

// File: tb/lc_bank_switch_tb_top.sv
module lc_bank_switch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, rd = 1'b1, zp = 1'b0, inh = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0] w_rd, w_wr;
  logic [7:0][23:0] w_ofs;

  int n_chk = 0, n_bad = 0;
  logic e_rd, e_wr, e_b1;

  always #5 clk = ~clk;

  lc_bank_switch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_read_i(rd),
    .acc_addr_i(addr), .zp_aux_i(zp), .lc_inhibit_i(inh),
    .win_rd_ram_o(w_rd), .win_wr_en_o(w_wr), .win_ofs_o(w_ofs)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_ofs(int b, int w);
    logic [23:0] base;
    base = (b == 0) ? ((zp && !inh) ? 24'h01_0000 : 24'h0) :
           (b == 1) ? 24'h01_0000 : 24'h7E_0000;
    if (b < 2 && inh) return base + (w ? 24'hE000 : 24'hD000);
    return base + (w ? 24'hE000 : (e_b1 ? 24'hC000 : 24'hD000));
  endfunction

  task automatic check_all(string tag);
    for (int b = 0; b < 4; b++) begin
      for (int w = 0; w < 2; w++) begin
        logic frc;
        frc = (b < 2) && inh;
        chk({tag, " rd"}, 32'(w_rd[2*b+w]), 32'(frc ? 1'b1 : e_rd));
        chk({tag, " wr"}, 32'(w_wr[2*b+w]), 32'(frc ? 1'b1 : e_wr));
        chk({tag, " ofs"}, 32'(w_ofs[2*b+w]), 32'(exp_ofs(b, w)));
      end
    end
  endtask

  task automatic acc(logic [15:0] a, logic r, logic v = 1'b1);
    @(negedge clk);
    addr = a; rd = r; valid = v;
    @(negedge clk);
    valid = 1'b0; addr = 16'h0000;
  endtask

  task automatic t_reset;
    e_rd = 0; e_wr = 1; e_b1 = 0;
    check_all("R1 reset");
  endtask

  task automatic t_snoop;
    acc(16'hC080, 1); e_rd = 1; e_wr = 0; e_b1 = 0;
    check_all("R2 setup");
    acc(16'hC09B, 1); acc(16'hC09B, 1);
    acc(16'hC07F, 1); acc(16'hC18B, 1);
    acc(16'hC08B, 1, 1'b0); acc(16'hC08B, 1, 1'b0);
    check_all("R2 ignored");
  endtask

  task automatic t_read_sel;
    for (int i = 0; i < 16; i++) begin
      acc(16'hC080 + 16'(i), 1'b0);
      chk("R3 read source", 32'(w_rd[4]), 32'((i % 4 == 0) || (i % 4 == 3)));
      chk("R3 read source b0", 32'(w_rd[1]), 32'((i % 4 == 0) || (i % 4 == 3)));
    end
  endtask

  task automatic t_bank;
    acc(16'hC088, 1); e_rd = 1; e_wr = 0; e_b1 = 1;
    check_all("R4 bank1");
    acc(16'hC080, 1); e_b1 = 0;
    check_all("R4 bank2");
  endtask

  task automatic t_write;
    acc(16'hC080, 1);
    acc(16'hC081, 1); e_rd = 0; e_wr = 0; e_b1 = 0;
    check_all("R5 single odd read");
    acc(16'hC081, 1); e_wr = 1;
    check_all("R5 pair sets");
    acc(16'hC080, 1);
    acc(16'hC083, 1);
    acc(16'h1234, 1);
    acc(16'hC083, 1); e_rd = 1; e_wr = 1;
    check_all("R5 interleaved pair");
  endtask

  task automatic t_clear;
    acc(16'hC08A, 0); e_rd = 0; e_wr = 0; e_b1 = 1;
    check_all("R6 even write clears");
    acc(16'hC081, 1); acc(16'hC081, 0); acc(16'hC081, 1); e_b1 = 0;
    check_all("R6 odd write breaks pair");
    acc(16'hC081, 1); e_wr = 1;
    check_all("R6 pair after break");
    acc(16'hC082, 1); e_wr = 0;
    check_all("R6 even read clears");
  endtask

  task automatic t_zp;
    acc(16'hC08B, 1); acc(16'hC08B, 1); e_rd = 1; e_wr = 1; e_b1 = 1;
    @(negedge clk); zp = 1; #1;
    check_all("R7 zp aux");
    chk("R7 bank00 equals bank01", 32'(w_ofs[0]), 32'(w_ofs[2]));
    @(negedge clk); zp = 0; #1;
    check_all("R7 zp off");
  endtask

  task automatic t_inhibit;
    acc(16'hC082, 1); e_rd = 0; e_wr = 0; e_b1 = 0;
    @(negedge clk); inh = 1; zp = 1; #1;
    check_all("R8 inhibit forces RAM");
    chk("R9 slow unaffected rd", 32'(w_rd[7:4]), 32'h0);
    acc(16'hC088, 1); e_rd = 1; e_b1 = 1;
    check_all("R9 slow follows under inhibit");
    @(negedge clk); inh = 0; zp = 0; #1;
    check_all("R8 release");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_snoop();
    t_read_sel();
    t_bank();
    t_write();
    t_clear();
    t_zp();
    t_inhibit();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule